// File: doc/BRIEF.md
# Multi-Ratio Clock Output Generator

This block turns one fast oscillator clock into a set of related clocks. It produces a double-rate clock, several in-phase base-rate clocks, a base-rate clock of opposite polarity, and a half-rate clock. The half-rate clock also goes back to the phase detector as the loop feedback, so the base rate ends up at twice the reference rate. A single shared phase counter drives every output, so the outputs keep a fixed phase relation to each other.

A synchronous master-reset input parks the double-rate clock and the first base-rate clocks low. The last base-rate clock, the inverted clock and the half-rate clock keep toggling. When master reset is released, the parked clocks rejoin at a count where all of them would be low anyway. They then run in phase with the free outputs, with no runt pulse.

A bypass input swaps the oscillator for the reference pin. The reference is synchronised to the fast clock, and each rising edge advances the divider chain by one step. This has no lower frequency limit, which suits slow board testing.

Top module: `multi_ratio_clkgen`

## Requirements
- R1: While rst_ni is low, dbl_o, half_o and every bit of base_o are 0, and inv_o is 1.
- R2: With pll_on_i high, the phase counter advances on every clk_i edge. dbl_o toggles on every edge, base_o every second edge and half_o every fourth edge. After reset release, dbl_o rises on the first edge, base_o on the second and half_o on the fourth.
- R3: When no gating is active, all base_o bits are equal, and inv_o is always the complement of the free-running base_o bit (the highest index).
- R4: half_o changes only on an edge where the free-running base_o bit falls.
- R5: From the first edge at which mr_i is sampled high, dbl_o and base_o[NUM_GATED-1:0] are held at 0. The remaining base_o bits, inv_o and half_o keep their normal sequence.
- R6: After mr_i is sampled low, the parked outputs reopen at the first edge whose new counter value has both low bits 0 (dbl_o and base_o low). This takes at most four counter advances. From then on the parked outputs match the free-running sequence exactly.
- R7: On the edge where the parked outputs reopen, all of them are 0, so no shortened high pulse appears.
- R8: With pll_on_i low (taking effect one edge after it is sampled), the counter advances once per rising edge of ref_i. The advance happens on the third clk_i edge after ref_i is first sampled high, behind two synchroniser stages and one edge-detect stage. A ref_i held at a constant level freezes every output.
- R9: Returning pll_on_i high resumes advancing every edge from the current count. The phase does not restart.
- R10: Master reset parks and releases the outputs the same way in bypass mode. There, the reopening count is reached through reference-driven advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock (twice the double-rate frequency) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_on_i | input | 1 | High: oscillator drives divider; low: reference bypass |
| ref_i | input | 1 | Reference clock, used as divider source in bypass |
| mr_i | input | 1 | Synchronous master reset for the parked outputs |
| dbl_o | output | 1 | Double-rate clock (gated by master reset) |
| base_o | output | NUM_BASE | In-phase base-rate clocks; low NUM_GATED bits gated |
| inv_o | output | 1 | Base-rate clock, 180 degrees shifted |
| half_o | output | 1 | Half-rate clock, also the feedback clock |

## Verification
Every output is a direct view of one shared counter and one gate flag. A wrong count therefore appears as a wrong output pattern on the very next edge, and a wrong gate flag appears as a parked output mismatching its free sibling. The scoreboard predicts the full output vector for every edge and compares it, so any divergence is flagged within one clock. The checker adds cross-output relations (polarity, half-rate edge alignment, reopen timing) that catch phase slips even when the scoreboard's stimulus happens not to reach them.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int CNT_W    = 3;
  localparam int TAP_DBL  = 0;
  localparam int TAP_BASE = 1;
  localparam int TAP_HALF = 2;

  typedef logic [CNT_W-1:0] phase_t;

  // next phase value: advance by one when a tick is present
  function automatic phase_t phase_step(input phase_t cur, input logic adv);
    phase_t nxt;
    nxt = adv ? phase_t'(cur + phase_t'(1)) : cur;
    return nxt;
  endfunction

  // a phase where every gateable tap is low
  function automatic logic is_quiet(input phase_t ph);
    return (ph[TAP_BASE:TAP_DBL] == '0);
  endfunction

endpackage

// File: rtl/clkgen_tick_src.sv
module clkgen_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_on_i,
  input  logic ref_i,
  output logic tick_o
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic             mode_q;
  logic [CHAIN-1:0] chain_q;
  logic             ref_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b1;
    else         mode_q <= pll_on_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[gi] <= 1'b0;
          else         chain_q[gi] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[gi] <= 1'b0;
          else         chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign ref_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  assign tick_o   = mode_q ? 1'b1 : ref_rise;

endmodule

// File: rtl/clkgen_phase_ctr.sv
module clkgen_phase_ctr
  import clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  output phase_t phase_d_o
);

  phase_t phase_q;

  assign phase_d_o = phase_step(phase_q, tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d_o;
  end

endmodule

// File: rtl/clkgen_gate_ctl.sv
module clkgen_gate_ctl
  import clkgen_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mr_i,
  input  phase_t phase_d_i,
  output logic   gate_d_o
);

  logic gate_q;

  // park immediately on master reset; reopen only at a quiet phase
  assign gate_d_o = mr_i ? 1'b0 : (gate_q | is_quiet(phase_d_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_d_o;
  end

endmodule

// File: rtl/clkgen_out_stage.sv
module clkgen_out_stage
  import clkgen_pkg::*;
#(
  parameter int NUM_BASE  = 3,
  parameter int NUM_GATED = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  phase_t              phase_d_i,
  input  logic                gate_d_i,
  output logic                dbl_o,
  output logic [NUM_BASE-1:0] base_o,
  output logic                inv_o,
  output logic                half_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_o  <= 1'b0;
      inv_o  <= 1'b1;
      half_o <= 1'b0;
    end else begin
      dbl_o  <= phase_d_i[TAP_DBL] & gate_d_i;
      inv_o  <= ~phase_d_i[TAP_BASE];
      half_o <= phase_d_i[TAP_HALF];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BASE; gi++) begin : g_base
      if (gi < NUM_GATED) begin : g_gated
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) base_o[gi] <= 1'b0;
          else         base_o[gi] <= phase_d_i[TAP_BASE] & gate_d_i;
        end
      end else begin : g_free
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) base_o[gi] <= 1'b0;
          else         base_o[gi] <= phase_d_i[TAP_BASE];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/multi_ratio_clkgen.sv
module multi_ratio_clkgen
  import clkgen_pkg::*;
#(
  parameter int NUM_BASE    = 3,
  parameter int NUM_GATED   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pll_on_i,
  input  logic                ref_i,
  input  logic                mr_i,
  output logic                dbl_o,
  output logic [NUM_BASE-1:0] base_o,
  output logic                inv_o,
  output logic                half_o
);

  logic   tick;
  phase_t phase_d;
  logic   gate_d;

  clkgen_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pll_on_i (pll_on_i),
    .ref_i    (ref_i),
    .tick_o   (tick)
  );

  clkgen_phase_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .phase_d_o (phase_d)
  );

  clkgen_gate_ctl u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mr_i      (mr_i),
    .phase_d_i (phase_d),
    .gate_d_o  (gate_d)
  );

  clkgen_out_stage #(.NUM_BASE(NUM_BASE), .NUM_GATED(NUM_GATED)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_d_i (phase_d),
    .gate_d_i  (gate_d),
    .dbl_o     (dbl_o),
    .base_o    (base_o),
    .inv_o     (inv_o),
    .half_o    (half_o)
  );

endmodule

// File: rtl/multi_ratio_clkgen_chk.sv
module multi_ratio_clkgen_chk #(
  parameter int NUM_BASE  = 3,
  parameter int NUM_GATED = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pll_on_i,
  input logic                mr_i,
  input logic                tick,
  input logic                gate_d,
  input logic                dbl_o,
  input logic [NUM_BASE-1:0] base_o,
  input logic                inv_o,
  input logic                half_o
);

  logic [2:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wait_q <= '0;
    else if (mr_i || gate_d)      wait_q <= '0;
    else if (tick && wait_q != 3'd7) wait_q <= wait_q + 3'd1;
  end

  // R3
  inv_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o != base_o[NUM_BASE-1]);

  // R5
  parked_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |=> (dbl_o == 1'b0 && base_o[NUM_GATED-1:0] == '0));

  // R4
  half_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(half_o) |-> $fell(base_o[NUM_BASE-1]));

  // R6
  in_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gate_d) |-> (base_o[0] == base_o[NUM_BASE-1]));

  // R7
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_d) |=> (dbl_o == 1'b0 && base_o[NUM_GATED-1:0] == '0));

  // R6
  reopen_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q <= 3'd3);

  // R2
  every_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pll_on_i) |-> tick);

endmodule

bind multi_ratio_clkgen multi_ratio_clkgen_chk #(
  .NUM_BASE  (NUM_BASE),
  .NUM_GATED (NUM_GATED)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pll_on_i (pll_on_i),
  .mr_i     (mr_i),
  .tick     (tick),
  .gate_d   (gate_d),
  .dbl_o    (dbl_o),
  .base_o   (base_o),
  .inv_o    (inv_o),
  .half_o   (half_o)
);

// File: tb/multi_ratio_clkgen_tb.sv
module multi_ratio_clkgen_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pll_on_i = 1'b1;
  logic       ref_i = 1'b0;
  logic       mr_i = 1'b0;
  logic       dbl_o, inv_o, half_o;
  logic [2:0] base_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // bench reference state
  int   m_ph = 0;
  bit   m_gate = 1;
  bit   m_mode = 1;
  bit   m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #4 clk_i = ~clk_i;

  multi_ratio_clkgen u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pll_on_i (pll_on_i),
    .ref_i    (ref_i),
    .mr_i     (mr_i),
    .dbl_o    (dbl_o),
    .base_o   (base_o),
    .inv_o    (inv_o),
    .half_o   (half_o)
  );

  function automatic logic [5:0] pack_vec(input int ph, input bit g);
    bit d, b, h;
    d = ((ph % 2) == 1);
    b = (((ph / 2) % 2) == 1);
    h = (((ph / 4) % 2) == 1);
    return {d & g, b, b & g, b & g, ~b, h};
  endfunction

  task automatic compare(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {dbl_o, base_o[2], base_o[1], base_o[0], inv_o, half_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  // driver: apply inputs for the next edge, predict, push after that edge
  task automatic step(input bit mr, input bit pll, input bit rf, input string tag);
    bit adv;
    mr_i = mr; pll_on_i = pll; ref_i = rf;
    adv = m_mode ? 1'b1 : (m_s2 & ~m_s3);
    if (adv) m_ph = (m_ph + 1) % 8;
    if (mr) m_gate = 0;
    else if ((m_ph % 4) == 0) m_gate = 1;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = rf; m_mode = pll;
    @(posedge clk_i); #1;
    exp_q.push_back(pack_vec(m_ph, m_gate));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk_i) compare(6'b000010, "R1");
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // R2 R3 R4 free running
    for (int i = 0; i < 20; i++) step(0, 1, 0, "R2,R3,R4");

    // R5 R6 R7 pulses of several lengths at shifting phases
    for (int len = 1; len <= 6; len++) begin
      for (int i = 0; i < len; i++) step(1, 1, 0, "R5");
      for (int i = 0; i < 5 + len; i++) step(0, 1, 0, "R6,R7");
    end

    // R8 bypass with a slow reference
    for (int i = 0; i < 60; i++) step(0, 0, ((i / 3) % 2) == 1, "R8");
    // R8 held high then held low: frozen
    for (int i = 0; i < 12; i++) step(0, 0, 1, "R8");
    for (int i = 0; i < 12; i++) step(0, 0, 0, "R8");
    // R8 very slow reference
    for (int i = 0; i < 80; i++) step(0, 0, ((i / 10) % 2) == 1, "R8");

    // R10 master reset during bypass
    for (int i = 0; i < 14; i++) step(1, 0, ((i / 2) % 2) == 1, "R10");
    for (int i = 0; i < 40; i++) step(0, 0, ((i / 2) % 2) == 1, "R10");

    // R9 back to oscillator, phase continues
    for (int i = 0; i < 24; i++) step(0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R5");
    for (int i = 0; i < 10; i++) step(0, 1, 0, "R6,R7");

    @(negedge clk_i); @(negedge clk_i);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule